// File: doc/BRIEF.md
# Crosspoint Chain Serial Loader

This block sits on the host side of a chain of one or more 16×16 analog crosspoint switch devices. The devices are cascaded, so each one's serial output feeds the next one's serial input. When a start request arrives, the block copies a full switch image from its configuration bus. It shifts that image out on a data line, one bit per rising edge of a serial clock, that it generates itself. It then pulses an active-low commit strobe, which moves the shifted bits into every device's switch latches at once.

The image bus holds one bit per switch, and a 1 closes that switch. Bit `d*GRID*GRID + y*GRID + x` controls the switch joining column X`x` to row Y`y` of device `d`. Device 0 is the one wired directly to this block. The block sends the image from its highest index down to index 0. That sends the far device's bits first, and within each device it steps through the columns of the top row, then the columns of each lower row.

All timing comes from the system clock and from parameters. The serial clock period is `SCLK_DIV` system clocks. The gap before the strobe and the strobe's low time are rounded up from nanosecond limits. Illegal settings are rejected at elaboration. While a load runs, `busy_o` is high and further start requests are ignored. `done_o` pulses for one cycle when the strobe returns high.

Top module: `xpt_chain_loader`

## Requirements
- R1: Out of reset `sclk_o` is 0, `strobe_n_o` is 1, `sdata_o` is 0, and `busy_o` and `done_o` are 0.
- R2: A `start_i` sampled while idle captures `cfg_i` and raises `busy_o` on the next cycle. A `start_i` or a `cfg_i` change while busy has no effect on the image committed and starts no second load.
- R3: Each load produces exactly `T = 256·N_DEV` rising edges of `sclk_o`.
- R4: Bit k (k = 0 first) sent on `sdata_o` is `cfg_i[T-1-k]`, where index `d*256 + y*16 + x` is device d, row y, column x. After the strobe, a chain of devices therefore holds exactly the captured image, and the first bit sent is device N_DEV-1's Y15/X15 bit.
- R5: While shifting, `sclk_o` is high for `SCLK_DIV/2` cycles and low for `SCLK_DIV - SCLK_DIV/2` cycles, including the low time before the first rise. `SCLK_DIV` must give a rate between 20 kHz and 5 MHz and phases of at least 100 ns, or elaboration fails. Outside shifting, `sclk_o` stays low.
- R6: `sdata_o` never changes while `sclk_o` is high. It changes only together with a falling edge or at capture, which gives setup and hold margins equal to the low and high phases.
- R7: `strobe_n_o` falls `SCLK_DIV/2 + ceil(65 ns / Tclk)` cycles after the last rising edge of `sclk_o`, and it stays low for `ceil(65 ns / Tclk)` cycles.
- R8: The strobe is back high within 5 ms of the last rising edge of `sclk_o`.
- R9: `strobe_n_o` is high except for a single low pulse per load, which occurs only after the shift is complete.
- R10: `done_o` is high for exactly one cycle, the cycle in which `strobe_n_o` returns high. `busy_o` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load request, honoured only when idle |
| cfg_i | input | N_DEV*GRID*GRID | Switch image, 1 = close |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Serial clock to the chain |
| sdata_o | output | 1 | Serial data to the chain |
| strobe_n_o | output | 1 | Active-low commit strobe |

## Verification
The assertions check several properties on every cycle. They check that the data line is frozen while the serial clock is high, that each high phase has the right length, and that the strobe stays parked high outside the commit phase. They also check the strobe's gap and low width, the rise count at the strobe's falling edge, the 5 ms deadline, and that the done pulse coincides with the strobe's release. Other behaviours show only in the bench scenarios. The bench models a cascade of device shift registers. It shows that bits arrive in the right device/row/column order across the cascade, that the image is captured at start, and that a start or a bus change during a load leaves the committed image untouched.

// File: rtl/xpt_ld_pkg.sv
package xpt_ld_pkg;

  typedef enum logic [1:0] {LD_IDLE, LD_SHIFT, LD_COMMIT} ld_state_e;
  typedef enum logic [1:0] {CM_IDLE, CM_GAP, CM_LOW, CM_DONE} cm_state_e;

  // Round a time in nanoseconds up to whole system clock cycles.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input longint unsigned clk_hz);
    longint unsigned num;
    num = 64'(ns) * clk_hz + 64'd999_999_999;
    return 32'(num / 64'd1_000_000_000);
  endfunction

  // Cycles per serial clock period are legal when the rate lies between
  // 20 kHz and 5 MHz and both phases last at least 100 ns. The 100 ns
  // phases also cover the 20 ns setup and 40 ns hold limits.
  function automatic bit sclk_div_ok(input int unsigned div,
                                     input longint unsigned clk_hz);
    int unsigned min_phase;
    longint unsigned min_div;
    longint unsigned max_div;
    min_phase = ns_to_cycles(100, clk_hz);
    min_div   = (clk_hz + 64'd4_999_999) / 64'd5_000_000;
    max_div   = clk_hz / 64'd20_000;
    return (64'(div) >= min_div) && (64'(div) <= max_div) &&
           (div / 2 >= min_phase) && (div - div / 2 >= min_phase);
  endfunction

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/xpt_ld_phase.sv
module xpt_ld_phase #(
  parameter int unsigned DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HIGH_CYC = DIV / 2;
  localparam int unsigned LOW_CYC  = DIV - HIGH_CYC;
  localparam int unsigned PW       = $clog2(DIV);
  localparam int unsigned HW       = $clog2(DIV + 1);

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_inc;
  logic          sclk_q;
  logic          wrap_w;

  assign wrap_w = (ph_q == PW'(DIV - 1));
  assign ph_inc = ph_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i || wrap_w) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_inc;
      sclk_q <= (ph_inc >= PW'(LOW_CYC));
    end
  end

  assign sclk_o = sclk_q;
  // Events flag the cycle whose closing edge moves the serial clock.
  assign rise_o = run_i && (ph_q == PW'(LOW_CYC - 1));
  assign fall_o = run_i && wrap_w;

  // Checker: length of each high phase, counted independently.
  logic [HW-1:0] hi_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_len_q <= '0;
    else if (sclk_q) hi_len_q <= hi_len_q + 1'b1;
    else             hi_len_q <= '0;
  end

  p_sclk_parked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !sclk_o);

  p_high_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (hi_len_q == HW'(HIGH_CYC)));

endmodule

// File: rtl/xpt_ld_image.sv
module xpt_ld_image #(
  parameter int unsigned T = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [T-1:0] cfg_i,
  input  logic         shift_i,
  output logic         bit_o,
  output logic         last_o
);
  localparam int unsigned CW = $clog2(T + 1);

  logic [T-1:0]  img_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      img_q <= cfg_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      img_q <= {img_q[T-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // The highest index leaves first: far device, top row, top column.
  assign bit_o  = img_q[T-1];
  assign last_o = (cnt_q == CW'(T - 1));

  p_shift_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> (cnt_q < CW'(T)));

endmodule

// File: rtl/xpt_ld_commit.sv
module xpt_ld_commit
  import xpt_ld_pkg::*;
#(
  parameter int unsigned GAP_CYC = 13,
  parameter int unsigned STB_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic strobe_n_o,
  output logic done_o,
  output logic active_o
);
  localparam int unsigned MAXC = (GAP_CYC > STB_CYC) ? GAP_CYC : STB_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 2);

  cm_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          stb_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CM_IDLE;
      cnt_q   <= '0;
      stb_n_q <= 1'b1;
    end else begin
      case (st_q)
        CM_IDLE: if (arm_i) begin
          st_q  <= CM_GAP;
          cnt_q <= '0;
        end
        CM_GAP: if (cnt_q == CW'(GAP_CYC - 1)) begin
          st_q    <= CM_LOW;
          cnt_q   <= '0;
          stb_n_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        CM_LOW: if (cnt_q == CW'(STB_CYC - 1)) begin
          st_q    <= CM_DONE;
          stb_n_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        CM_DONE: st_q <= CM_IDLE;
        default: st_q <= CM_IDLE;
      endcase
    end
  end

  assign strobe_n_o = stb_n_q;
  assign done_o     = (st_q == CM_DONE);
  assign active_o   = (st_q != CM_IDLE);

  // Checker counters: strobe low run and cycles since arming.
  logic [CW-1:0] low_len_q;
  logic [CW:0]   quiet_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len_q <= '0;
      quiet_q   <= '0;
    end else begin
      low_len_q <= stb_n_q ? '0 : low_len_q + 1'b1;
      if (arm_i)              quiet_q <= (CW+1)'(1);
      else if (!(&quiet_q))   quiet_q <= quiet_q + 1'b1;
    end
  end

  p_strobe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n_o) |-> (low_len_q == CW'(STB_CYC)));

  p_strobe_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n_o) |-> (quiet_q == (CW+1)'(GAP_CYC + 1)));

  p_done_on_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $rose(strobe_n_o));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/xpt_chain_loader.sv
module xpt_chain_loader
  import xpt_ld_pkg::*;
#(
  parameter int unsigned     N_DEV       = 2,
  parameter int unsigned     GRID        = 16,
  parameter longint unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned     SCLK_DIV    = 40,
  parameter int unsigned     GAP_NS      = 65,
  parameter int unsigned     STB_NS      = 65,
  parameter int unsigned     LIMIT_NS    = 5_000_000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [N_DEV*GRID*GRID-1:0] cfg_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       sclk_o,
  output logic                       sdata_o,
  output logic                       strobe_n_o
);
  localparam int unsigned T         = N_DEV * GRID * GRID;
  localparam int unsigned HIGH_CYC  = SCLK_DIV / 2;
  localparam int unsigned GAP_CYC   = at_least_one(ns_to_cycles(GAP_NS, CLK_HZ));
  localparam int unsigned STB_CYC   = at_least_one(ns_to_cycles(STB_NS, CLK_HZ));
  localparam int unsigned LIMIT_CYC = 32'(CLK_HZ / 64'd1_000_000_000 * 64'(LIMIT_NS)
                                      + (CLK_HZ % 64'd1_000_000_000) * 64'(LIMIT_NS)
                                        / 64'd1_000_000_000);
  localparam int unsigned TAIL_CYC  = HIGH_CYC + GAP_CYC + STB_CYC;
  localparam int unsigned RW        = $clog2(T + 2);
  localparam int unsigned SW        = $clog2(LIMIT_CYC + 2);

  if (!sclk_div_ok(SCLK_DIV, CLK_HZ)) begin : g_bad_div
    $error("serial clock divider gives an illegal rate or phase width");
  end
  if (TAIL_CYC > LIMIT_CYC) begin : g_bad_tail
    $error("commit strobe cannot finish inside the hold deadline");
  end

  ld_state_e st_q;

  logic accept_w;
  logic run_w;
  logic rise_w;
  logic fall_w;
  logic last_w;
  logic arm_w;
  logic cm_done_w;
  logic cm_active_w;

  assign accept_w = start_i && (st_q == LD_IDLE);
  assign run_w    = (st_q == LD_SHIFT);
  assign arm_w    = fall_w && last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LD_IDLE;
    end else begin
      case (st_q)
        LD_IDLE:   if (accept_w)  st_q <= LD_SHIFT;
        LD_SHIFT:  if (arm_w)     st_q <= LD_COMMIT;
        LD_COMMIT: if (cm_done_w) st_q <= LD_IDLE;
        default:                  st_q <= LD_IDLE;
      endcase
    end
  end

  xpt_ld_phase #(.DIV(SCLK_DIV)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_w),
    .sclk_o (sclk_o),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  xpt_ld_image #(.T(T)) u_image (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept_w),
    .cfg_i   (cfg_i),
    .shift_i (fall_w),
    .bit_o   (sdata_o),
    .last_o  (last_w)
  );

  xpt_ld_commit #(.GAP_CYC(GAP_CYC), .STB_CYC(STB_CYC)) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_w),
    .strobe_n_o (strobe_n_o),
    .done_o     (cm_done_w),
    .active_o   (cm_active_w)
  );

  assign busy_o = (st_q != LD_IDLE);
  assign done_o = cm_done_w;

  // Checker counters: rises per load and cycles since the latest rise.
  logic [RW-1:0] rises_q;
  logic [SW-1:0] since_rise_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises_q      <= '0;
      since_rise_q <= '0;
    end else begin
      if (accept_w)    rises_q <= '0;
      else if (rise_w) rises_q <= rises_q + 1'b1;
      if (rise_w)                                since_rise_q <= '0;
      else if (since_rise_q != SW'(LIMIT_CYC + 1)) since_rise_q <= since_rise_q + 1'b1;
    end
  end

  p_rise_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n_o) |-> (rises_q == RW'(T)));

  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(sdata_o));

  p_commit_deadline_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (since_rise_q <= SW'(LIMIT_CYC)));

  p_strobe_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_active_w |-> strobe_n_o);

  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != LD_SHIFT) |=> !sclk_o);

endmodule

// File: tb/xpt_chain_loader_tb.sv
module xpt_chain_loader_tb;
  localparam int NDEV      = 2;
  localparam int G         = 16;
  localparam int T         = NDEV * G * G;
  localparam int DIV       = 40;
  localparam int PERIOD_NS = 5;
  localparam int HIGH_EXP  = DIV / 2;
  localparam int LOW_EXP   = DIV - DIV / 2;
  localparam int STB_EXP   = (65 + PERIOD_NS - 1) / PERIOD_NS;
  localparam int GAP_TOTAL = HIGH_EXP + STB_EXP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [T-1:0] cfg = '0;
  logic busy_o, done_o, sclk_o, sdata_o, strobe_n_o;

  always #2.5 clk = ~clk;

  xpt_chain_loader #(.N_DEV(NDEV), .GRID(G), .SCLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_i(cfg),
    .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o),
    .sdata_o(sdata_o), .strobe_n_o(strobe_n_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Monitor: model of the device chain and timing observers.
  logic [T-1:0] sr = '0, latched = '0;
  logic p_sclk = 0, p_sdata = 0, p_stb = 1, p_busy = 0, p_done = 0;
  logic first_bit = 0;
  int cyc = 0, last_rise = 0, gap = 0, hi_run = 0, lo_run = 0, stb_low = 0;
  int stb_width = 0, rises = 0, bad_hi = 0, bad_lo = 0, bad_dat = 0;
  int stb_falls = 0, done_cnt = 0;
  logic done_at_rise = 0, busy_after_done = 1, finished = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (busy_o && !p_busy) lo_run = 0;
      if (sclk_o && !p_sclk) begin
        if (lo_run != LOW_EXP) bad_lo++;
        if (rises == 0) first_bit = sdata_o;
        sr = {sr[T-2:0], sdata_o};
        rises++;
        last_rise = cyc;
        hi_run = 0;
      end
      if (!sclk_o && p_sclk) begin
        if (hi_run != HIGH_EXP) bad_hi++;
        lo_run = 0;
      end
      if (sclk_o && (sdata_o != p_sdata)) bad_dat++;
      if (!strobe_n_o && p_stb) begin
        gap = cyc - last_rise;
        latched = sr;
        stb_falls++;
        stb_low = 0;
      end
      if (strobe_n_o && !p_stb) begin
        stb_width = stb_low;
        done_at_rise = done_o;
      end
      if (done_o) done_cnt++;
      if (p_done) begin
        busy_after_done = busy_o;
        finished = 1;
      end
      if (sclk_o) hi_run++; else lo_run++;
      if (!strobe_n_o) stb_low++;
      p_sclk = sclk_o; p_sdata = sdata_o; p_stb = strobe_n_o;
      p_busy = busy_o; p_done = done_o;
    end
  end

  function automatic logic [T-1:0] make_pat(input int sel);
    logic [T-1:0] v = '0;
    for (int d = 0; d < NDEV; d++)
      for (int y = 0; y < G; y++)
        for (int x = 0; x < G; x++) begin
          int i = d * G * G + y * G + x;
          case (sel)
            0: v[i] = ((x + 3 * y + 5 * d) % 7) == 0;
            1: v[i] = (i == T - 1) || (i == 0);
            2: v[i] = 1'b1;
            default: v[i] = ((x ^ y) & 1) == 1;
          endcase
        end
    return v;
  endfunction

  task automatic run_load(input logic [T-1:0] img, input bit poke,
                          input logic [T-1:0] alt);
    int rises_end;
    @(posedge clk);
    rises = 0; bad_hi = 0; bad_lo = 0; bad_dat = 0; stb_falls = 0;
    done_cnt = 0; finished = 0; done_at_rise = 0; busy_after_done = 1;
    cfg = img;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    if (poke) begin
      repeat (3000) @(posedge clk);
      @(negedge clk) begin cfg = alt; start = 1'b1; end
      @(negedge clk) start = 1'b0;
    end
    while (!finished) @(posedge clk);
    check(rises == T, "R3", "rising edges", rises, T);
    check($countones(latched ^ img) == 0, "R4", "mismatching latched bits",
          $countones(latched ^ img), 0);
    check(first_bit == img[T-1], "R4", "first bit sent", first_bit, img[T-1]);
    check(bad_hi == 0 && bad_lo == 0, "R5", "bad phase widths", bad_hi + bad_lo, 0);
    check(bad_dat == 0, "R6", "data changes while clock high", bad_dat, 0);
    check(gap == GAP_TOTAL, "R7", "last rise to strobe fall", gap, GAP_TOTAL);
    check(stb_width == STB_EXP, "R7", "strobe low width", stb_width, STB_EXP);
    check((gap + stb_width) * PERIOD_NS <= 5_000_000, "R8", "rise to release ns",
          (gap + stb_width) * PERIOD_NS, 5_000_000);
    check(stb_falls == 1, "R9", "strobe pulses", stb_falls, 1);
    check(done_cnt == 1 && done_at_rise, "R10", "done pulses at release",
          done_cnt, 1);
    check(busy_after_done == 1'b0, "R10", "busy after done", busy_after_done, 0);
    rises_end = rises;
    repeat (100) @(posedge clk);
    check(!busy_o && rises == rises_end && stb_falls == 1, "R2",
          "activity after load", rises - rises_end + stb_falls, 1);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sclk_o == 0 && sdata_o == 0, "R1", "serial lines in reset", {sclk_o, sdata_o}, 0);
    check(strobe_n_o == 1, "R1", "strobe in reset", strobe_n_o, 1);
    check(busy_o == 0 && done_o == 0, "R1", "busy/done in reset", {busy_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sclk_o == 0 && strobe_n_o == 1 && !busy_o, "R1", "idle after reset",
          {sclk_o, strobe_n_o, busy_o}, 2);
    run_load(make_pat(0), 1'b0, '0);
    run_load(make_pat(1), 1'b0, '0);
    run_load(make_pat(2), 1'b0, '0);
    run_load(make_pat(3), 1'b1, ~make_pat(3));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule